// File: doc/BRIEF.md
# Fetch Program-Counter Sequencer

This block owns the program counter of a five-stage in-order pipeline and decides which address is fetched each cycle. With no redirect, the counter steps forward by one instruction width. Branches are resolved by the decode stage, which presents a resolution to the sequencer in the same cycle. The resolution is a qualifier, a direction bit and a target address. Depending on a policy bit, the sequencer handles a taken branch in one of two ways. It can kill the fall-through instruction that was fetched behind the branch. Or it can treat that instruction as an architectural delay slot that always runs.

The sequencer also tracks whether the fetch/decode register holds a live instruction. A killed wrong-path instruction is signalled as a bubble through `squash`, so later stages drop it. A pipeline stall freezes the counter and all of the sequencer's state. The decode stage keeps presenting the frozen instruction during a stall, so its resolution is acted on in the first cycle the stall is released. The policy bit is meant to be changed only while reset is held.

Top module: `fetch_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `fetch_pc` = RESET_VEC, `fetch_valid` low and `squash` low. After release, the first unreset edge raises `fetch_valid` and still presents RESET_VEC. The edge after that presents RESET_VEC + STEP.
- R2: With a valid fetch, no stall and no accepted taken resolution, the next `fetch_pc` is the current one plus STEP (STEP = 4 by default).
- R3: A cycle with `stall` high leaves `fetch_pc`, `fetch_valid` and `squash` unchanged at the following edge.
- R4: With `mode_delayed` = 0 (predict-not-taken), an accepted taken resolution loads `br_target` into `fetch_pc` at the next edge. It also raises `squash` for one cycle, marking the instruction then in the fetch/decode register as a bubble. The cost is exactly one lost decode cycle.
- R5: With `mode_delayed` = 0, an untaken branch costs no cycle. Fetch continues sequentially and no bubble is produced.
- R6: With `mode_delayed` = 1 (delayed branch), `squash` never rises. The instruction fetched right after a branch (the slot) always reaches decode as a live instruction.
- R7: With `mode_delayed` = 1, the instruction decoded after the slot is the branch target if the branch was taken. Otherwise it is the slot address plus STEP.
- R8: With `mode_delayed` = 1, a resolution presented while the slot instruction is in decode has no effect. Fetch continues with the redirect or fall-through chosen by the first branch.
- R9: A resolution presented while the fetch/decode register holds a squashed bubble has no effect. `fetch_pc` steps by STEP and `squash` falls.
- R10: With `mode_delayed` = 0, the number of bubbles seen in decode equals the number of taken branches executed before the last live instruction.
- R11: A resolution presented during a stall is applied on the first cycle after `stall` falls, provided decode still presents it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_delayed | input | 1 | Branch policy: 0 predict-not-taken with squash, 1 single delay slot |
| stall | input | 1 | Freeze the counter and the fetch/decode register |
| br_valid | input | 1 | Decode presents a branch resolution this cycle |
| br_taken | input | 1 | Resolved direction, 1 = taken |
| br_target | input | AW | Branch target address |
| fetch_pc | output | AW | Address fetched this cycle |
| fetch_valid | output | 1 | The fetch at `fetch_pc` is genuine |
| squash | output | 1 | The fetch/decode register holds a killed wrong-path instruction |

## Verification
The bench runs seeded branch-dense programs in both policies, with and without random stalls. It compares every live decoded address against a stream walked arithmetically from the program. Several design errors would show up in that stream. Forgetting the kill would let a wrong-path instruction execute. Honouring a branch sitting in a delay slot would make execution jump to its target. Acting on a resolution while stalled, or dropping it after the stall, would skip or repeat the target. The bench also counts bubbles against taken branches, to expose a two-cycle penalty or a bubble produced in delayed mode. It checks that a stalled edge moves nothing and that the reset vector is presented twice after reset.

// File: rtl/fetch_seq_pkg.sv
package fetch_seq_pkg;

   typedef enum logic {
      POL_SQUASH = 1'b0,
      POL_DELAY  = 1'b1
   } policy_e;

   localparam int DEF_AW        = 16;
   localparam int DEF_STEP      = 4;

endpackage

// File: rtl/fetch_seq_resolve.sv
module fetch_seq_resolve
   import fetch_seq_pkg::*;
#(
   parameter bit HAS_SLOT = 1'b1
) (
   input  policy_e policy,
   input  logic    stall,
   input  logic    dec_live,
   input  logic    in_slot,
   input  logic    br_valid,
   input  logic    br_taken,
   output logic    accept,
   output logic    redirect,
   output logic    squash_d,
   output logic    slot_d
);

   // a resolution only counts for a live, non-slot decode that is moving on
   assign accept   = br_valid && dec_live && !in_slot && !stall;
   assign redirect = accept && br_taken;

   generate
      if (HAS_SLOT) begin : g_slot
         assign squash_d = redirect && (policy == POL_SQUASH);
         assign slot_d   = accept && (policy == POL_DELAY);
      end else begin : g_noslot
         logic unused_policy;
         assign unused_policy = policy;
         assign squash_d = redirect;
         assign slot_d   = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/fetch_seq_next.sv
module fetch_seq_next #(
   parameter int AW   = 16,
   parameter int STEP = 4
) (
   input  logic [AW-1:0] pc_q,
   input  logic          fv_q,
   input  logic          redirect,
   input  logic [AW-1:0] target,
   output logic [AW-1:0] pc_d
);

   localparam logic [AW-1:0] STEP_W = AW'(STEP);

   always_comb begin
      if (!fv_q) begin
         pc_d = pc_q;
      end else if (redirect) begin
         pc_d = target;
      end else begin
         pc_d = pc_q + STEP_W;
      end
   end

endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
   import fetch_seq_pkg::*;
#(
   parameter int          AW        = DEF_AW,
   parameter int          STEP      = DEF_STEP,
   parameter logic [AW-1:0] RESET_VEC = AW'(64),
   parameter bit          HAS_SLOT  = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          mode_delayed,
   input  logic          stall,
   input  logic          br_valid,
   input  logic          br_taken,
   input  logic [AW-1:0] br_target,
   output logic [AW-1:0] fetch_pc,
   output logic          fetch_valid,
   output logic          squash
);

   localparam logic [AW-1:0] STEP_W = AW'(STEP);

   initial begin
      assert (AW >= 4) else $error("fetch_seq: AW too small");
      assert (STEP >= 1) else $error("fetch_seq: STEP must be positive");
      assert ((int'(RESET_VEC) % STEP) == 0) else $error("fetch_seq: RESET_VEC misaligned");
   end

   policy_e       pol;
   logic [AW-1:0] pc_q, pc_d;
   logic          fv_q, dv_q, sq_q, slot_q;
   logic          accept, redirect, squash_d, slot_d;

   assign pol = policy_e'(mode_delayed);

   fetch_seq_resolve #(.HAS_SLOT(HAS_SLOT)) u_resolve (
      .policy   (pol),
      .stall    (stall),
      .dec_live (dv_q && !sq_q),
      .in_slot  (slot_q),
      .br_valid (br_valid),
      .br_taken (br_taken),
      .accept   (accept),
      .redirect (redirect),
      .squash_d (squash_d),
      .slot_d   (slot_d)
   );

   fetch_seq_next #(.AW(AW), .STEP(STEP)) u_next (
      .pc_q     (pc_q),
      .fv_q     (fv_q),
      .redirect (redirect),
      .target   (br_target),
      .pc_d     (pc_d)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q   <= RESET_VEC;
         fv_q   <= 1'b0;
         dv_q   <= 1'b0;
         sq_q   <= 1'b0;
         slot_q <= 1'b0;
      end else if (!stall) begin
         pc_q   <= pc_d;
         fv_q   <= 1'b1;
         dv_q   <= fv_q;
         sq_q   <= squash_d;
         slot_q <= slot_d;
      end
   end

   assign fetch_pc    = pc_q;
   assign fetch_valid = fv_q;
   assign squash      = sq_q;

   // R1: cycle after a reset edge shows the reset vector, nothing valid
   p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (fetch_pc == RESET_VEC && !fetch_valid && !squash));

   // R2: sequential stepping without redirect
   p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
      (fetch_valid && !stall && !redirect) |=> fetch_pc == $past(fetch_pc) + STEP_W);

   // R3: stall freezes the visible state
   p_stall_hold_r3: assert property (@(posedge clk) disable iff (rst)
      stall |=> ($stable(fetch_pc) && $stable(fetch_valid) && $stable(squash)));

   // R4: taken resolution lands on the target, and kills in squash policy
   p_target_load_r4: assert property (@(posedge clk) disable iff (rst)
      redirect |=> fetch_pc == $past(br_target));
   p_kill_pnt_r4: assert property (@(posedge clk) disable iff (rst)
      (redirect && !mode_delayed) |=> squash);

   // R5: no taken resolution, no bubble
   p_no_bubble_r5: assert property (@(posedge clk) disable iff (rst)
      (!stall && !redirect) |=> !squash);

   // R6: delay policy never kills
   p_no_kill_delay_r6: assert property (@(posedge clk) disable iff (rst)
      mode_delayed |-> !squash);

   // R8: slot instruction in decode cannot redirect
   p_slot_ignored_r8: assert property (@(posedge clk) disable iff (rst)
      (slot_q && !stall) |=> fetch_pc == $past(fetch_pc) + STEP_W);

   // R9: bubble in decode cannot redirect and clears
   p_bubble_ignored_r9: assert property (@(posedge clk) disable iff (rst)
      (sq_q && !stall) |=> (!squash && fetch_pc == $past(fetch_pc) + STEP_W));

endmodule

// File: tb/fetch_seq_bench.sv
module fetch_seq_bench;

   localparam int            AW  = 16;
   localparam logic [AW-1:0] VEC = 16'h0040;
   localparam int            N   = 200;
   localparam int            MW  = 64;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst = 1'b1;
   logic          mode_delayed = 1'b0;
   logic          stall = 1'b0;
   logic          br_valid, br_taken;
   logic [AW-1:0] br_target;
   logic [AW-1:0] fetch_pc;
   logic          fetch_valid, squash;

   logic          prog_br [MW];
   logic          prog_tk [MW];
   logic [5:0]    prog_tg [MW];

   logic          ifid_v;
   logic [AW-1:0] ifid_a;

   logic [AW-1:0] exp_a [N+4];
   bit            exp_s [N+4];
   logic [15:0]   lfsr;
   int            nchk = 0;
   int            nbad = 0;

   fetch_seq u_fetch_seq (
      .clk          (clk),
      .rst          (rst),
      .mode_delayed (mode_delayed),
      .stall        (stall),
      .br_valid     (br_valid),
      .br_taken     (br_taken),
      .br_target    (br_target),
      .fetch_pc     (fetch_pc),
      .fetch_valid  (fetch_valid),
      .squash       (squash)
   );

   // fetch/decode register and combinational decode of the program array
   always @(posedge clk) begin
      if (rst) begin
         ifid_v <= 1'b0;
         ifid_a <= '0;
      end else if (!stall) begin
         ifid_v <= fetch_valid;
         ifid_a <= fetch_pc;
      end
   end

   assign br_valid  = ifid_v && prog_br[ifid_a[7:2]];
   assign br_taken  = prog_tk[ifid_a[7:2]];
   assign br_target = AW'({prog_tg[ifid_a[7:2]], 2'b00});

   function automatic logic [AW-1:0] tgt_of(input logic [AW-1:0] a);
      return AW'({prog_tg[a[7:2]], 2'b00});
   endfunction

   task automatic rnd(output logic [15:0] v);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      v = lfsr;
   endtask

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] expv);
      nchk++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
      end
   endtask

   task automatic build(input bit mode, input logic [15:0] seed);
      logic [15:0]   r;
      logic [AW-1:0] pc;
      int            k;
      lfsr = seed;
      for (int i = 0; i < MW; i++) begin
         rnd(r);
         prog_br[i] = (r[1:0] == 2'b00);
         prog_tk[i] = r[2];
         prog_tg[i] = r[8:3];
      end
      pc = VEC;
      k  = 0;
      while (k < N + 2) begin
         exp_a[k] = pc;
         exp_s[k] = 1'b0;
         k++;
         if (prog_br[pc[7:2]]) begin
            if (mode) begin
               exp_a[k] = pc + 4;
               exp_s[k] = 1'b1;
               k++;
               pc = prog_tk[pc[7:2]] ? tgt_of(pc) : pc + 8;
            end else begin
               pc = prog_tk[pc[7:2]] ? tgt_of(pc) : pc + 4;
            end
         end else begin
            pc = pc + 4;
         end
      end
   endtask

   task automatic run(input bit mode, input logic [15:0] seed, input bit stall_en);
      logic [15:0]   r;
      int            k, bubbles, cyc, taken_exp;
      bit            prev_stall, prev_sq, cur_stalled, r9_next, r11_next, pb;
      logic [AW-1:0] prev_pc, pa;
      string         tag;
      build(mode, seed);
      @(negedge clk);
      rst = 1'b1;
      mode_delayed = mode;
      stall = 1'b0;
      repeat (2) @(negedge clk);
      check(fetch_pc == VEC && !fetch_valid && !squash, "R1 reset state",
            {fetch_pc, 3'b0, fetch_valid, 3'b0, squash}, {VEC, 8'h00});
      rst = 1'b0;
      @(negedge clk);
      check(fetch_valid && fetch_pc == VEC, "R1 first fetch", {fetch_pc, 7'b0, fetch_valid},
            {VEC, 8'h01});
      @(negedge clk);
      check(fetch_pc == VEC + 4, "R2 second fetch", fetch_pc, VEC + 4);
      k = 0; bubbles = 0; cyc = 0;
      prev_stall = 0; prev_sq = 0; prev_pc = '0;
      cur_stalled = 0; r9_next = 0; r11_next = 0;
      while (k < N && cyc < 5000) begin
         rnd(r);
         stall = stall_en && (r[1:0] == 2'b00);
         #1;
         if (prev_stall)
            check(fetch_pc == prev_pc && squash == prev_sq, "R3 stall hold",
                  {fetch_pc, 7'b0, squash}, {prev_pc, 7'b0, prev_sq});
         if (ifid_v && stall && !squash) cur_stalled = 1;
         if (ifid_v && !stall) begin
            if (squash) begin
               bubbles++;
               if (prog_br[ifid_a[7:2]]) r9_next = 1;
            end else begin
               if (k == 0) tag = "R1 vector";
               else if (r9_next) tag = "R9 bubble branch ignored";
               else if (r11_next) tag = "R11 resolution after stall";
               else begin
                  pa = exp_a[k-1];
                  pb = prog_br[pa[7:2]];
                  if (mode) begin
                     if (exp_s[k]) tag = "R6 slot executes";
                     else if (exp_s[k-1]) tag = pb ? "R8 slot branch ignored" : "R7 after slot";
                     else tag = "R2 sequential";
                  end else begin
                     if (pb && prog_tk[pa[7:2]]) tag = "R4 taken target";
                     else if (pb) tag = "R5 untaken fall-through";
                     else tag = "R2 sequential";
                  end
               end
               check(ifid_a == exp_a[k], tag, ifid_a, exp_a[k]);
               r9_next  = 0;
               r11_next = cur_stalled && prog_br[ifid_a[7:2]];
               k++;
            end
            cur_stalled = 0;
         end
         prev_stall = stall;
         prev_pc    = fetch_pc;
         prev_sq    = squash;
         cyc++;
         @(negedge clk);
      end
      stall = 1'b0;
      check(k == N, "R2 progress (run timeout)", k, N);
      taken_exp = 0;
      if (!mode)
         for (int i = 0; i < N - 1; i++)
            if (prog_br[exp_a[i][7:2]] && prog_tk[exp_a[i][7:2]]) taken_exp++;
      check(bubbles == taken_exp, mode ? "R6 no bubbles" : "R10 bubble count",
            bubbles, taken_exp);
   endtask

   initial begin
      #2000000;
      nbad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
      $finish;
   end

   initial begin
      run(1'b0, 16'hACE1, 1'b0);
      run(1'b0, 16'h1234, 1'b1);
      run(1'b0, 16'h0F0F, 1'b1);
      run(1'b1, 16'hBEEF, 1'b0);
      run(1'b1, 16'h5A5A, 1'b1);
      run(1'b1, 16'h7777, 1'b1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
      $finish;
   end

endmodule